// File: doc/BRIEF.md
# Interrupt-Paced Register Access Engine

This block sits on the host side of a link to a security-module slave. It accepts one register read or register write at a time and turns it into transfers on a byte-transfer port. The bit-level bus master behind that port lies outside the block. The byte-transfer port has a start pulse, a direction flag, a byte count, a done strobe and a NACK flag.

Reads always take two transfers: a one-byte address transfer, then a data transfer. Between the two, the engine waits for a falling edge on an active-low ready line from the device. A write goes out as one transfer that carries the address byte followed by the payload, and the engine then waits for the same ready edge. When the interrupt is disabled, every ready wait becomes a fixed delay. A transfer that ends in NACK is retried after a fixed gap, up to a bounded number of attempts. Each access ends with one response carrying a status code and, for reads, the returned bytes.

Top module: `regacc_engine`

## Requirements
- R1: A read issues a 1-byte non-read transfer holding only the register address. After the ready wait it issues a read transfer of exactly `req_len` bytes. It then responds with status 0 (success), with `rsp_rdata` byte i equal to byte i of that transfer's returned data. Byte i of any data vector lies at bits [8i+7:8i].
- R2: The address byte has the locality in bits 7:4 and a base offset in bits 3:0. The base offset is chosen by `req_sel`: 0 selects 0x0, 1 selects 0x1, 2 selects 0x5 and 3 selects 0x6.
- R3: A write issues exactly one non-read transfer of `req_len`+1 bytes. Byte 0 is the address byte and byte i+1 is payload byte i.
- R4: A write with `req_len` above BUF_BYTES-1 issues no transfer and responds with status 3 (bad length).
- R5: A write whose ready wait expires without an edge still responds with status 0, and only after READY_TIMEOUT cycles have passed.
- R6: A read whose ready wait expires without an edge responds with status 2 (timeout) and issues no data transfer.
- R7: A transfer that ends in NACK is retried at most MAX_TRIES attempts in total. The next start comes no sooner than RETRY_GAP cycles after the failing done. When the last attempt also fails, the access responds with status 1 (bus error).
- R8: With `irq_enable` low, each ready wait lasts a fixed NOIRQ_DELAY cycles, and edges on the ready line do not shorten it.
- R9: A falling ready edge that arrives while the address transfer is still in progress is kept, and it releases the wait that follows.
- R10: Ready edges while no access is in flight are ignored, and a rising edge never counts as ready.
- R11: After reset `req_ready` is high. It stays low from acceptance until the response. `rsp_valid` is a one-cycle pulse, and `req_ready` returns the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_enable | input | 1 | 1: pace on ready edges; 0: fixed delay |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Engine idle, request accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_sel | input | 2 | Register select (base offset) |
| req_loc | input | 4 | Locality number |
| req_len | input | LW | Byte count |
| req_wdata | input | 8*BUF_BYTES | Write payload, byte i at [8i+7:8i] |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 bus error, 2 timeout, 3 bad length |
| rsp_rdata | output | 8*BUF_BYTES | Read data |
| xfer_start | output | 1 | Transfer start pulse |
| xfer_read | output | 1 | Transfer direction, 1 read |
| xfer_len | output | LW | Transfer byte count |
| xfer_wdata | output | 8*BUF_BYTES | Bytes to send, address at byte 0 |
| xfer_done | input | 1 | Transfer finished |
| xfer_nack | input | 1 | Transfer failed, valid with done |
| xfer_rdata | input | 8*BUF_BYTES | Bytes received |
| dev_rdy_n | input | 1 | Asynchronous active-low device ready line |

## Verification
The bench builds the engine with READY_TIMEOUT 200, NOIRQ_DELAY 60 and RETRY_GAP 25. It keeps BUF_BYTES at 64 and MAX_TRIES at 3. These short windows make the read timeout, the ignored write timeout, the fixed no-interrupt delay and the retry spacing all measurable in cycles, so their bounds can be checked within a short run. The full 64-byte buffer keeps the 63-byte write limit and the rejected 64-byte write at their real sizes.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEND, ST_BUSY, ST_GAP, ST_WAIT, ST_RESP
    } st_e;

    typedef enum logic [1:0] {
        PH_WRITE, PH_RADDR, PH_RDATA
    } ph_e;

    localparam logic [1:0] RSP_OK      = 2'd0;
    localparam logic [1:0] RSP_BUSERR  = 2'd1;
    localparam logic [1:0] RSP_TIMEOUT = 2'd2;
    localparam logic [1:0] RSP_BADLEN  = 2'd3;

    // base offset of each selectable register
    function automatic logic [3:0] reg_base(input logic [1:0] sel);
        case (sel)
            2'd0:    reg_base = 4'h0;
            2'd1:    reg_base = 4'h1;
            2'd2:    reg_base = 4'h5;
            default: reg_base = 4'h6;
        endcase
    endfunction

endpackage

// File: rtl/regacc_timer.sv
module regacc_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/regacc_rdy_edge.sv
module regacc_rdy_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_n,
    input  logic arm,
    input  logic clear,
    output logic seen
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic armed;
        logic seen;
    } edge_t;

    edge_t d, q;
    logic  fall;

    always_comb begin
        d      = q;
        d.s1   = rdy_n;
        d.s2   = q.s1;
        d.prev = q.s2;
        fall   = q.prev & ~q.s2;
        if (clear) begin
            d.armed = 1'b0;
            d.seen  = 1'b0;
        end else begin
            if (arm) d.armed = 1'b1;
            if (q.armed && fall) d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1, armed: 1'b0, seen: 1'b0};
        else        q <= d;
    end

    assign seen = q.seen;

    // R10: a latched edge only comes from an armed detector
    a_r10_seen_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.seen) |-> $past(q.armed));
    // R10: clearing at access end drops any latched edge
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !q.seen);
endmodule

// File: rtl/regacc_engine.sv
module regacc_engine
    import regacc_pkg::*;
#(
    parameter int BUF_BYTES     = 64,
    parameter int MAX_TRIES     = 3,
    parameter int RETRY_GAP     = 6000,
    parameter int READY_TIMEOUT = 75000000,
    parameter int NOIRQ_DELAY   = 2000000,
    localparam int BW = 8 * BUF_BYTES,
    localparam int LW = $clog2(BUF_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_enable,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [1:0]    req_sel,
    input  logic [3:0]    req_loc,
    input  logic [LW-1:0] req_len,
    input  logic [BW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [1:0]    rsp_status,
    output logic [BW-1:0] rsp_rdata,
    output logic          xfer_start,
    output logic          xfer_read,
    output logic [LW-1:0] xfer_len,
    output logic [BW-1:0] xfer_wdata,
    input  logic          xfer_done,
    input  logic          xfer_nack,
    input  logic [BW-1:0] xfer_rdata,
    input  logic          dev_rdy_n
);
    localparam int TMAX_A = (RETRY_GAP > NOIRQ_DELAY) ? RETRY_GAP : NOIRQ_DELAY;
    localparam int TMAX   = (TMAX_A > READY_TIMEOUT) ? TMAX_A : READY_TIMEOUT;
    localparam int TW     = $clog2(TMAX + 1);
    localparam int TRW    = $clog2(MAX_TRIES + 1);

    localparam logic [TW-1:0]  T_GAP   = TW'(RETRY_GAP);
    localparam logic [TW-1:0]  T_RDY   = TW'(READY_TIMEOUT);
    localparam logic [TW-1:0]  T_NOIRQ = TW'(NOIRQ_DELAY);
    localparam logic [LW-1:0]  MAX_PAY = LW'(BUF_BYTES - 1);
    localparam logic [TRW-1:0] LAST_TRY = TRW'(MAX_TRIES - 1);

    typedef struct packed {
        st_e           st;
        ph_e           ph;
        logic [TRW-1:0] tries;
        logic [7:0]    addr;
        logic [LW-1:0] len;
        logic [BW-1:0] wdata;
        logic [1:0]    status;
        logic [BW-1:0] rdata;
    } regs_t;

    regs_t         d, q;
    logic          tmr_load, tmr_zero, arm, clr, rdy_seen;
    logic [TW-1:0] tmr_val;

    regacc_rdy_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .rdy_n (dev_rdy_n),
        .arm   (arm),
        .clear (clr),
        .seen  (rdy_seen)
    );

    regacc_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        arm      = 1'b0;
        clr      = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr  = {req_loc, reg_base(req_sel)};
                    d.len   = req_len;
                    d.wdata = req_wdata;
                    d.tries = '0;
                    d.rdata = '0;
                    arm     = 1'b1;
                    if (req_write && (req_len > MAX_PAY)) begin
                        d.status = RSP_BADLEN;
                        d.st     = ST_RESP;
                    end else begin
                        d.ph = req_write ? PH_WRITE : PH_RADDR;
                        d.st = ST_SEND;
                    end
                end
            end
            ST_SEND: d.st = ST_BUSY;
            ST_BUSY: begin
                if (xfer_done) begin
                    if (xfer_nack) begin
                        if (q.tries == LAST_TRY) begin
                            d.status = RSP_BUSERR;
                            d.st     = ST_RESP;
                        end else begin
                            d.tries  = q.tries + 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = T_GAP;
                            d.st     = ST_GAP;
                        end
                    end else begin
                        d.tries = '0;
                        if (q.ph == PH_RDATA) begin
                            d.rdata  = xfer_rdata;
                            d.status = RSP_OK;
                            d.st     = ST_RESP;
                        end else begin
                            tmr_load = 1'b1;
                            tmr_val  = irq_enable ? T_RDY : T_NOIRQ;
                            d.st     = ST_WAIT;
                        end
                    end
                end
            end
            ST_GAP: if (tmr_zero) d.st = ST_SEND;
            ST_WAIT: begin
                if ((irq_enable && rdy_seen) || (!irq_enable && tmr_zero)) begin
                    if (q.ph == PH_WRITE) begin
                        d.status = RSP_OK;
                        d.st     = ST_RESP;
                    end else begin
                        d.ph = PH_RDATA;
                        d.st = ST_SEND;
                    end
                end else if (tmr_zero) begin
                    // write ignores an expired wait, read aborts
                    d.status = (q.ph == PH_WRITE) ? RSP_OK : RSP_TIMEOUT;
                    d.st     = ST_RESP;
                end
            end
            ST_RESP: begin
                clr  = 1'b1;
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign rsp_valid  = (q.st == ST_RESP);
    assign rsp_status = q.status;
    assign rsp_rdata  = q.rdata;
    assign xfer_start = (q.st == ST_SEND);
    assign xfer_read  = (q.ph == PH_RDATA);
    assign xfer_len   = (q.ph == PH_WRITE) ? q.len + 1'b1 :
                        (q.ph == PH_RADDR) ? LW'(1) : q.len;
    assign xfer_wdata = {q.wdata[BW-9:0], q.addr};

    // R11: response and transfer start are single-cycle pulses
    a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);
    // R11: no new request is taken while a transfer starts
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !req_ready);
    // R11: idle again right after a response
    a_r11_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);
    // R4: an outgoing write never exceeds the buffer
    a_r4_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !xfer_read) |-> (xfer_len <= LW'(BUF_BYTES)));
    // R7: attempt counter stays inside its bound
    a_r7_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.tries < TRW'(MAX_TRIES));
endmodule

// File: tb/regacc_engine_test.sv
module regacc_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int BB    = 64;
    localparam int BW    = 8 * BB;
    localparam int LW    = $clog2(BB + 1);
    localparam int TRDY  = 200;
    localparam int TNIRQ = 60;
    localparam int TGAP  = 25;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          irq_enable;
    logic          req_valid, req_ready, req_write;
    logic [1:0]    req_sel;
    logic [3:0]    req_loc;
    logic [LW-1:0] req_len;
    logic [BW-1:0] req_wdata;
    logic          rsp_valid;
    logic [1:0]    rsp_status;
    logic [BW-1:0] rsp_rdata;
    logic          xfer_start, xfer_read;
    logic [LW-1:0] xfer_len;
    logic [BW-1:0] xfer_wdata;
    logic          xfer_done, xfer_nack;
    logic [BW-1:0] xfer_rdata;
    logic          dev_rdy_n;

    int nchecks = 0;
    int nerr    = 0;
    int cyc     = 0;

    // slave model state
    int          n_log = 0;
    int          nack_left = 0;
    bit          early_rdy = 0;
    bit          late_rdy  = 0;
    int          pulse_due = 32'h3fff_ffff;
    int          hold_until = 0;
    int          log_start [256];
    int          log_done  [256];
    bit          log_rd    [256];
    int          log_len   [256];
    logic [BW-1:0] log_wd  [256];

    regacc_engine #(
        .BUF_BYTES(BB), .MAX_TRIES(3), .RETRY_GAP(TGAP),
        .READY_TIMEOUT(TRDY), .NOIRQ_DELAY(TNIRQ)
    ) uut (
        .clk(clk), .rst_n(rst_n), .irq_enable(irq_enable),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_sel(req_sel), .req_loc(req_loc), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_len(xfer_len),
        .xfer_wdata(xfer_wdata), .xfer_done(xfer_done), .xfer_nack(xfer_nack),
        .xfer_rdata(xfer_rdata), .dev_rdy_n(dev_rdy_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        for (int i = 0; i < BB; i++) xfer_rdata[8*i +: 8] = 8'h30 + 8'(i);
    end

    // ready line: held low by the test, or pulsed by the slave model
    initial begin
        dev_rdy_n = 1'b1;
        forever begin
            @(negedge clk);
            dev_rdy_n = !((cyc < hold_until) || (cyc >= pulse_due && cyc < pulse_due + 3));
        end
    end

    // byte-transfer slave model
    initial begin
        xfer_done = 1'b0;
        xfer_nack = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (xfer_start) begin
                if (n_log < 256) begin
                    log_start[n_log] = cyc;
                    log_rd[n_log]    = xfer_read;
                    log_len[n_log]   = int'(xfer_len);
                    log_wd[n_log]    = xfer_wdata;
                end
                if (early_rdy && !xfer_read) pulse_due = cyc;
                repeat (3) @(negedge clk);
                xfer_done = 1'b1;
                xfer_nack = (nack_left > 0);
                if (nack_left > 0) nack_left = nack_left - 1;
                if (n_log < 256) log_done[n_log] = cyc;
                if (late_rdy && !xfer_read && !xfer_nack) pulse_due = cyc + 5;
                n_log = n_log + 1;
                @(negedge clk);
                xfer_done = 1'b0;
                xfer_nack = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", nchecks + 1, nerr + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int            base;
    logic [1:0]    st;
    logic [BW-1:0] rd;
    int            dur;

    task automatic access(input bit wr, input logic [1:0] sel, input logic [3:0] loc,
                          input int len, input logic [BW-1:0] wd);
        int guard = 0;
        int busy_ready = 0;
        int t0;
        @(negedge clk);
        base      = n_log;
        req_write = wr;
        req_sel   = sel;
        req_loc   = loc;
        req_len   = LW'(len);
        req_wdata = wd;
        req_valid = 1'b1;
        t0        = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && guard < 5000) begin
            if (req_ready) busy_ready++;
            @(negedge clk);
            guard++;
        end
        chk(guard < 5000, "R11 response arrives", guard, 0);
        chk(busy_ready == 0, "R11 req_ready low while busy", busy_ready, 0);
        st  = rsp_status;
        rd  = rsp_rdata;
        dur = cyc - t0;
        @(negedge clk);
        chk(!rsp_valid, "R11 rsp_valid single cycle", rsp_valid, 0);
        chk(req_ready, "R11 ready after response", req_ready, 1);
    endtask

    function automatic logic [BW-1:0] payload();
        logic [BW-1:0] v;
        for (int i = 0; i < BB; i++) v[8*i +: 8] = 8'h10 + 8'(i);
        return v;
    endfunction

    task automatic t_reset_state;
        chk(req_ready == 1'b1, "R11 reset req_ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R11 reset rsp_valid", rsp_valid, 0);
        chk(xfer_start == 1'b0, "R11 reset xfer_start", xfer_start, 0);
    endtask

    task automatic t_read_ok;
        late_rdy = 1; early_rdy = 0; irq_enable = 1;
        access(1'b0, 2'd1, 4'd2, 4, '0);
        chk(st == 2'd0, "R1 read status", st, 0);
        chk(n_log - base == 2, "R1 read transfer count", n_log - base, 2);
        chk(!log_rd[base] && log_len[base] == 1, "R1 address transfer 1 byte write",
            log_len[base], 1);
        chk(log_wd[base][7:0] == 8'h21, "R2 address sel1 loc2", log_wd[base][7:0], 8'h21);
        chk(log_rd[base+1] && log_len[base+1] == 4, "R1 data transfer read 4",
            log_len[base+1], 4);
        for (int i = 0; i < 4; i++)
            chk(rd[8*i +: 8] == 8'h30 + 8'(i), "R1 read data byte", rd[8*i +: 8], 8'h30 + i);
    endtask

    task automatic t_addr_map;
        logic [1:0] sels [3] = '{2'd3, 2'd2, 2'd0};
        logic [3:0] locs [3] = '{4'd0, 4'd4, 4'd15};
        logic [7:0] exps [3] = '{8'h06, 8'h45, 8'hF0};
        late_rdy = 1; early_rdy = 0; irq_enable = 1;
        for (int k = 0; k < 3; k++) begin
            access(1'b0, sels[k], locs[k], 2, '0);
            chk(log_wd[base][7:0] == exps[k], "R2 address byte", log_wd[base][7:0], exps[k]);
        end
    endtask

    task automatic t_write_ok;
        logic [BW-1:0] p = payload();
        late_rdy = 1; early_rdy = 0; irq_enable = 1;
        access(1'b1, 2'd2, 4'd1, 5, p);
        chk(st == 2'd0, "R3 write status", st, 0);
        chk(n_log - base == 1, "R3 one transfer", n_log - base, 1);
        chk(!log_rd[base] && log_len[base] == 6, "R3 write length", log_len[base], 6);
        chk(log_wd[base][7:0] == 8'h15, "R3 R2 address byte first", log_wd[base][7:0], 8'h15);
        for (int i = 0; i < 5; i++)
            chk(log_wd[base][8*(i+1) +: 8] == 8'h10 + 8'(i), "R3 payload byte",
                log_wd[base][8*(i+1) +: 8], 8'h10 + i);
        access(1'b1, 2'd0, 4'd0, 63, p);
        chk(st == 2'd0 && log_len[base] == 64, "R3 max write length", log_len[base], 64);
        chk(log_wd[base][8*63 +: 8] == 8'h4E, "R3 last payload byte",
            log_wd[base][8*63 +: 8], 8'h4E);
    endtask

    task automatic t_badlen;
        access(1'b1, 2'd2, 4'd0, 64, payload());
        chk(st == 2'd3, "R4 oversize write status", st, 3);
        chk(n_log - base == 0, "R4 no transfer", n_log - base, 0);
    endtask

    task automatic t_retry;
        int gap;
        late_rdy = 1; early_rdy = 0; irq_enable = 1;
        nack_left = 2;
        access(1'b1, 2'd1, 4'd0, 4, payload());
        chk(st == 2'd0, "R7 success on third attempt", st, 0);
        chk(n_log - base == 3, "R7 attempt count", n_log - base, 3);
        for (int k = 0; k < 2; k++) begin
            gap = log_start[base+k+1] - log_done[base+k];
            chk(gap >= TGAP && gap <= TGAP + 4, "R7 retry spacing", gap, TGAP);
        end
        nack_left = 3;
        access(1'b1, 2'd1, 4'd0, 4, payload());
        chk(st == 2'd1, "R7 bus error after last attempt", st, 1);
        chk(n_log - base == 3, "R7 no fourth attempt", n_log - base, 3);
        nack_left = 0;
    endtask

    task automatic t_timeouts;
        late_rdy = 0; early_rdy = 0; irq_enable = 1;
        access(1'b0, 2'd0, 4'd0, 1, '0);
        chk(st == 2'd2, "R6 read timeout status", st, 2);
        chk(n_log - base == 1, "R6 no data transfer", n_log - base, 1);
        access(1'b1, 2'd0, 4'd0, 1, payload());
        chk(st == 2'd0, "R5 write timeout ignored", st, 0);
        chk(dur >= TRDY, "R5 waited full timeout", dur, TRDY);
    endtask

    task automatic t_noirq;
        int gap;
        late_rdy = 1; early_rdy = 0; irq_enable = 0;
        access(1'b0, 2'd1, 4'd0, 4, '0);
        gap = log_start[base+1] - log_done[base];
        chk(st == 2'd0 && n_log - base == 2, "R8 read completes", st, 0);
        chk(gap >= TNIRQ && gap <= TNIRQ + 4, "R8 fixed delay", gap, TNIRQ);
        irq_enable = 1;
    endtask

    task automatic t_early;
        int gap;
        late_rdy = 0; early_rdy = 1; irq_enable = 1;
        access(1'b0, 2'd1, 4'd0, 4, '0);
        gap = log_start[base+1] - log_done[base];
        chk(st == 2'd0, "R9 early edge kept", st, 0);
        chk(gap < 15, "R9 wait released promptly", gap, 15);
        early_rdy = 0;
    endtask

    task automatic t_idle_edges;
        late_rdy = 0; early_rdy = 0; irq_enable = 1;
        @(negedge clk);
        hold_until = cyc + 3;
        repeat (12) @(negedge clk);
        access(1'b0, 2'd1, 4'd0, 4, '0);
        chk(st == 2'd2, "R10 idle edge ignored", st, 2);
        @(negedge clk);
        hold_until = cyc + 40;
        repeat (12) @(negedge clk);
        access(1'b0, 2'd1, 4'd0, 4, '0);
        chk(st == 2'd2, "R10 rising edge ignored", st, 2);
    endtask

    initial begin
        rst_n = 1'b0; irq_enable = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_sel = '0; req_loc = '0; req_len = '0; req_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_read_ok();
        t_addr_map();
        t_write_ok();
        t_badlen();
        t_retry();
        t_timeouts();
        t_noirq();
        t_early();
        t_idle_edges();
        $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
        $finish;
    end
endmodule